// File: doc/BRIEF.md
# Dual-Channel Arrival Skew Timeout Monitor

This block sits beside a pair of filter input channels and watches their sample-valid strobes. When one channel delivers a sample while the other has not, it clears a 16-bit skew counter and starts counting system clocks. It stops counting when the partner channel delivers its matching sample. If the count reaches a programmable threshold first, a sticky error bit is set and an interrupt line goes high.

Software sees two 32-bit words through a simple register port. The control word holds a run bit, a check-enable bit and the W1C error bit. The timing word holds a 13-bit period field, counted in units of eight clocks, and the live counter, which software can only read. The period is locked against writes while the run bit is set.

Top module: `skew_timeout_monitor`

## Requirements
- R1: After reset the control word (address 0) reads 0x00000000, the timing word (address 1) reads 0x00000080 (period 0x0010, counter 0), and `irq` is 0.
- R2: While checking is active and no measurement is open, a cycle with exactly one strobe high clears the counter to 0 at that edge. The counter then rises by 1 on every following clock.
- R3: The partner strobe closes the measurement. Counting the first edge as 0, the counter then holds the number of edges from the first arrival to the partner's arrival, and keeps that value until a new measurement starts.
- R4: The threshold is period×8 clocks. The error bit is set when the count reaches the threshold, including when the partner arrives on that same edge. A partner that arrives one edge earlier sets no error.
- R5: When both strobes are high in the same cycle while idle, no measurement starts and the counter does not change.
- R6: Checking is active only when the check-enable bit (control bit 1) is 1 and the period is nonzero. Otherwise strobes start nothing and no error is raised.
- R7: The error bit (control bit 8) stays set until software writes 1 to bit 8 of the control word. A timeout on the same edge as that write leaves the bit set. `irq` equals the error bit.
- R8: The period sits in bits 15:3 of the timing word, and bits 2:0 read 0. Writes to the period take effect only while the run bit (control bit 0) is 0. While the run bit is 1 they leave the period unchanged.
- R9: The counter occupies timing word bits 31:16, and register writes never change it.
- R10: After a timeout the counter holds at the threshold value. Further strobes from the first channel are ignored. The partner's arrival closes the measurement, and the next lone strobe restarts the counter from 0.
- R11: Repeat strobes from the channel that opened the measurement do not restart or disturb the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vld_a | input | 1 | Sample-valid strobe of channel A |
| vld_b | input | 1 | Sample-valid strobe of channel B |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 control/status, 1 timing |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| irq | output | 1 | Error interrupt, high while the error bit is set |

## Verification
A strobe or register write presented in one cycle becomes visible in the counter, the error bit, `irq` and the register words right after the next rising edge. Only one register stage lies on each of those paths, and the read-data mux is combinational. The bench drives inputs at the falling edge. It updates its reference model at the rising edge and compares the model against `irq` and the selected word two time units after that edge. Directed reads are made just after a falling edge, once the edges that the scenario counts have all passed. Skews one edge below and exactly at the threshold are measured, and a timeout is made to land on the same edge as a clear write.

// File: rtl/skew_mon_pkg.sv
// Package: shared state encoding and register layout constants for the
// arrival skew timeout monitor. Assumes a 32-bit register word.
package skew_mon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no measurement open
        ST_WAIT = 2'd1,   // first arrival seen, counting
        ST_LATE = 2'd2    // threshold hit, waiting for partner
    } skew_st_e;

    localparam int unsigned WORD_W       = 32;
    localparam logic        ADDR_CTRL    = 1'b0;
    localparam logic        ADDR_TIME    = 1'b1;
    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_CHK_BIT = 1;
    localparam int unsigned CTRL_ERR_BIT = 8;

endpackage

// File: rtl/skew_arrival.sv
// Module: classifies the two valid strobes for the timer. "lone" marks a
// cycle with exactly one strobe, "lone_b" tells which, and "other_hit"
// marks the partner of the channel that opened the current measurement.
// Assumes strobes are synchronous to the system clock.
module skew_arrival (
    input  logic vld_a,
    input  logic vld_b,
    input  logic first_b,
    output logic lone,
    output logic lone_b,
    output logic other_hit
);

    // Decode arrival events from the raw strobes.
    always_comb begin
        lone      = vld_a ^ vld_b;
        lone_b    = vld_b & ~vld_a;
        other_hit = first_b ? vld_a : vld_b;
    end

endmodule

// File: rtl/skew_timer.sv
// Module: measurement state machine and skew counter. Opens a measurement
// on a lone arrival, counts clocks, closes on the partner arrival and pulses
// err_set when the count reaches period << STEP_SHIFT. Assumes the period
// and enable inputs are registered elsewhere.
module skew_timer
    import skew_mon_pkg::*;
#(
    parameter int unsigned PER_W      = 13,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned STEP_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_a,
    input  logic             vld_b,
    input  logic             chk_en,
    input  logic [PER_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             err_set
);

    localparam int unsigned THR_W = PER_W + STEP_SHIFT;
    localparam int unsigned EXT_W = CNT_W + 1;

    skew_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             fb_q, fb_d;
    logic             active;
    logic [EXT_W-1:0] thr;
    logic [EXT_W-1:0] cnt_nx;
    logic             lone, lone_b, other_hit;

    skew_arrival u_arr (
        .vld_a     (vld_a),
        .vld_b     (vld_b),
        .first_b   (fb_q),
        .lone      (lone),
        .lone_b    (lone_b),
        .other_hit (other_hit)
    );

    // Threshold in clocks, enable qualifier and incremented count.
    always_comb begin
        active = chk_en && (period != '0);
        thr    = {{(EXT_W-THR_W){1'b0}}, period, {STEP_SHIFT{1'b0}}};
        cnt_nx = {1'b0, cnt_q} + EXT_W'(1);
    end

    // Next-state logic of the measurement.
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        fb_d    = fb_q;
        err_set = 1'b0;
        if (!active) begin
            st_d = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (lone) begin
                        cnt_d = '0;
                        fb_d  = lone_b;
                        st_d  = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    cnt_d = cnt_nx[CNT_W-1:0];
                    if (cnt_nx >= thr) begin
                        err_set = 1'b1;
                        st_d    = ST_LATE;
                    end
                    if (other_hit) st_d = ST_IDLE;
                end
                ST_LATE: begin
                    if (other_hit) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State, counter and first-channel registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            fb_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            fb_q  <= fb_d;
        end
    end

    assign cnt = cnt_q;

    // R2: a lone arrival while idle and active clears the counter.
    a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && active && lone) |=> (cnt_q == '0));
    // R2: an open measurement advances by one per clock.
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && active) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R3: with no new measurement the counter holds.
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !(active && lone)) |=> $stable(cnt_q));
    // R5: simultaneous strobes open nothing.
    a_r5_tie_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && vld_a && vld_b) |=> (st_q == ST_IDLE));
    // R6: no error while checking is inactive.
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !err_set);
    // R10: counter frozen after a timeout.
    a_r10_late_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATE) |=> $stable(cnt_q));

endmodule

// File: rtl/skew_regs.sv
// Module: register words of the monitor. Holds run, check-enable, the
// period (locked while run is set) and the sticky W1C error bit; muxes the
// read data. Assumes a single write port with a one-bit word address.
module skew_regs
    import skew_mon_pkg::*;
#(
    parameter int unsigned      PER_W   = 13,
    parameter int unsigned      PER_LSB = 3,
    parameter int unsigned      CNT_W   = 16,
    parameter logic [PER_W-1:0] PER_RST = 13'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              err_set,
    output logic [WORD_W-1:0] rdata,
    output logic              chk_en,
    output logic [PER_W-1:0]  period,
    output logic              err
);

    logic             run_q, chk_q, err_q;
    logic [PER_W-1:0] per_q;
    logic             wr_ctrl, wr_time, err_clr;
    logic             unused_wbits;

    // Decode the write strobes.
    always_comb begin
        wr_ctrl = wr && (addr == ADDR_CTRL);
        wr_time = wr && (addr == ADDR_TIME);
        err_clr = wr_ctrl && wdata[CTRL_ERR_BIT];
    end

    assign unused_wbits = ^wdata;

    // Control bits and the locked period field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            chk_q <= 1'b0;
            per_q <= PER_RST;
        end else begin
            if (wr_ctrl) begin
                run_q <= wdata[CTRL_RUN_BIT];
                chk_q <= wdata[CTRL_CHK_BIT];
            end
            if (wr_time && !run_q) per_q <= wdata[PER_LSB +: PER_W];
        end
    end

    // Sticky error bit: hardware set wins over software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end

    // Read-data mux of the two words.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[CTRL_RUN_BIT] = run_q;
            rdata[CTRL_CHK_BIT] = chk_q;
            rdata[CTRL_ERR_BIT] = err_q;
        end else begin
            rdata[WORD_W-1 -: CNT_W]  = cnt;
            rdata[PER_LSB +: PER_W]   = per_q;
        end
    end

    assign chk_en = chk_q;
    assign period = per_q;
    assign err    = err_q;

    // R7: error bit persists unless cleared.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q);
    // R7: a timeout always leaves the bit set.
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> err_q);
    // R8: period frozen while running.
    a_r8_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && wr_time) |=> $stable(per_q));

endmodule

// File: rtl/skew_timeout_monitor.sv
// Module: top of the dual-channel arrival skew timeout monitor. Joins the
// register words and the skew timer; irq follows the sticky error bit.
// Assumes both strobes and the register port are in the clk domain.
module skew_timeout_monitor
    import skew_mon_pkg::*;
#(
    parameter int unsigned      PER_W      = 13,
    parameter int unsigned      PER_LSB    = 3,
    parameter int unsigned      CNT_W      = 16,
    parameter int unsigned      STEP_SHIFT = 3,
    parameter logic [PER_W-1:0] PER_RST    = 13'h0010
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vld_a,
    input  logic        vld_b,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);

    logic             chk_en;
    logic [PER_W-1:0] period;
    logic [CNT_W-1:0] cnt;
    logic             err_set;
    logic             err;

    skew_regs #(
        .PER_W   (PER_W),
        .PER_LSB (PER_LSB),
        .CNT_W   (CNT_W),
        .PER_RST (PER_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .cnt     (cnt),
        .err_set (err_set),
        .rdata   (reg_rdata),
        .chk_en  (chk_en),
        .period  (period),
        .err     (err)
    );

    skew_timer #(
        .PER_W      (PER_W),
        .CNT_W      (CNT_W),
        .STEP_SHIFT (STEP_SHIFT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_a   (vld_a),
        .vld_b   (vld_b),
        .chk_en  (chk_en),
        .period  (period),
        .cnt     (cnt),
        .err_set (err_set)
    );

    assign irq = err;

    // R7: interrupt line tracks the error bit seen at the control word.
    a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CTRL) |-> (irq == reg_rdata[CTRL_ERR_BIT]));

endmodule

// File: tb/sim_skew_timeout_monitor.sv
module sim_skew_timeout_monitor;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_a = 1'b0;
    logic        vld_b = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int m_state = 0;   // 0 idle, 1 counting, 2 timed out
    int m_first_b = 0;
    int m_cnt = 0;
    int m_err = 0;
    int m_run = 0;
    int m_chk = 0;
    int m_per = 16;

    skew_timeout_monitor u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_a     (vld_a),
        .vld_b     (vld_b),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_word(input logic a);
        if (a == 1'b0) return 32'(m_run) | (32'(m_chk) << 1) | (32'(m_err) << 8);
        return (32'(m_cnt) << 16) | (32'(m_per) << 3);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // model update at each rising edge, compare shortly after
    always @(posedge clk) begin
        logic a, b, other, wr0, wr1, active, eset;
        a = vld_a; b = vld_b;
        wr0 = reg_wr && !reg_addr;
        wr1 = reg_wr && reg_addr;
        if (!rst_n) begin
            m_state = 0; m_first_b = 0; m_cnt = 0; m_err = 0;
            m_run = 0; m_chk = 0; m_per = 16;
        end else begin
            active = (m_chk == 1) && (m_per != 0);
            eset = 0;
            other = m_first_b ? a : b;
            if (!active) m_state = 0;
            else if (m_state == 0) begin
                if (a != b) begin m_cnt = 0; m_first_b = b; m_state = 1; end
            end else if (m_state == 1) begin
                m_cnt = m_cnt + 1;
                if (m_cnt >= m_per * 8) begin eset = 1; m_state = 2; end
                if (other) m_state = 0;
            end else begin
                if (other) m_state = 0;
            end
            if (eset) m_err = 1;
            else if (wr0 && reg_wdata[8]) m_err = 0;
            if (wr1 && m_run == 0) m_per = int'(reg_wdata[15:3]);
            if (wr0) begin m_run = reg_wdata[0]; m_chk = reg_wdata[1]; end
        end
        #2;
        if (rst_n && !done) begin
            check({cur_req, " irq"}, {31'b0, irq}, 32'(m_err));
            check({cur_req, " word"}, reg_rdata, exp_word(reg_addr));
        end
    end

    task automatic pulse(input bit on_b);
        if (on_b) vld_b = 1'b1; else vld_a = 1'b1;
        @(negedge clk);
        vld_a = 1'b0; vld_b = 1'b0;
    endtask

    task automatic both();
        vld_a = 1'b1; vld_b = 1'b1;
        @(negedge clk);
        vld_a = 1'b0; vld_b = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] keep;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values
        cur_req = "R1";
        rd(1'b0, d); check("R1 ctrl", d, 32'h0);
        rd(1'b1, d); check("R1 time", d, 32'h0000_0080);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R8 period field position, low bits read zero
        cur_req = "R8";
        wr(1'b0, 32'h2);
        wr(1'b1, 32'h0000_0017);
        rd(1'b1, d); check("R8 period write", d & 32'hFFFF, 32'h0010);

        // R2 R3 skew of 5 edges
        cur_req = "R3";
        pulse(0);
        rd(1'b1, d); check("R2 start at zero", d >> 16, 32'd0);
        idle(3);
        rd(1'b1, d); check("R2 counting", d >> 16, 32'd3);
        idle(1); pulse(1);
        rd(1'b1, d); check("R3 skew 5", d >> 16, 32'd5);
        idle(4);
        rd(1'b1, d); check("R3 held", d >> 16, 32'd5);

        // R4 one below threshold (16), channel B first
        cur_req = "R4";
        pulse(1); idle(14); pulse(0);
        rd(1'b1, d); check("R4 skew 15 count", d >> 16, 32'd15);
        check("R4 skew 15 no err", {31'b0, irq}, 32'h0);
        // R4 exactly at threshold
        pulse(0); idle(15); pulse(1);
        rd(1'b1, d); check("R4 skew 16 count", d >> 16, 32'd16);
        check("R4 skew 16 err", {31'b0, irq}, 32'h1);

        // R7 sticky then cleared
        cur_req = "R7";
        idle(5);
        check("R7 sticky", {31'b0, irq}, 32'h1);
        wr(1'b0, 32'h102);
        rd(1'b0, d); check("R7 cleared", d, 32'h2);

        // R10 hold after timeout, first-channel repeat ignored
        cur_req = "R10";
        pulse(0); idle(30);
        rd(1'b1, d); check("R10 hold at thr", d >> 16, 32'd16);
        pulse(0); idle(2);
        rd(1'b1, d); check("R10 repeat ignored", d >> 16, 32'd16);
        pulse(1);
        pulse(1);
        rd(1'b1, d); check("R10 restart", d >> 16, 32'd0);
        idle(4); pulse(0);
        rd(1'b1, d); check("R10 new skew", d >> 16, 32'd5);
        wr(1'b0, 32'h102);

        // R11 repeat strobe during counting
        cur_req = "R11";
        pulse(0); idle(2); pulse(0); idle(2); pulse(1);
        rd(1'b1, d); check("R11 repeat no restart", d >> 16, 32'd6);

        // R5 tie
        cur_req = "R5";
        both(); idle(6);
        rd(1'b1, d); check("R5 tie no start", d >> 16, 32'd6);

        // R6 disabled by enable bit, then by zero period
        cur_req = "R6";
        wr(1'b0, 32'h0);
        pulse(0); idle(20); pulse(1);
        rd(1'b1, d); check("R6 enable off count", d >> 16, 32'd6);
        check("R6 enable off irq", {31'b0, irq}, 32'h0);
        wr(1'b0, 32'h2);
        wr(1'b1, 32'h0);
        pulse(1); idle(20);
        rd(1'b1, d); check("R6 period zero count", d >> 16, 32'd6);
        check("R6 period zero irq", {31'b0, irq}, 32'h0);
        wr(1'b1, 32'h10);

        // R8 lock while running
        cur_req = "R8";
        wr(1'b0, 32'h3);
        wr(1'b1, 32'h28);
        rd(1'b1, d); check("R8 locked", d & 32'hFFFF, 32'h0010);
        wr(1'b0, 32'h2);
        wr(1'b1, 32'h28);
        rd(1'b1, d); check("R8 unlocked", d & 32'hFFFF, 32'h0028);
        wr(1'b1, 32'h10);

        // R9 counter is read-only
        cur_req = "R9";
        rd(1'b1, keep);
        wr(1'b1, 32'hFFFF_0010);
        rd(1'b1, d); check("R9 counter untouched", d, keep);

        // R7 timeout coincides with clear write: set wins
        cur_req = "R7";
        pulse(0); idle(15);
        wr(1'b0, 32'h102);
        check("R7 set beats clear", {31'b0, irq}, 32'h1);
        pulse(1);
        wr(1'b0, 32'h102);
        check("R7 clear after", {31'b0, irq}, 32'h0);

        idle(3);
        finish_run();
    end

endmodule